// File: doc/BRIEF.md
# Local Memory Region Decoder

This block sits between a processor's load/store port, two local SRAMs (one instruction-side, one data-side) and the external bus. For each access it picks one target. It then either forms a word index into that SRAM, with the byte lanes the access needs, or forwards the access unchanged to the external bus. Read data from the selected target is aligned and returned one cycle after the request.

Two window registers set where each local SRAM appears. A coprocessor-style register write port updates them. The instruction window always starts at address zero. The data window starts at a programmable 4 KiB-aligned base. Each window's size is a power of two, and it may be larger than the SRAM behind it. In that case the SRAM repeats across the whole window.

Top module: `tcm_region_decoder`

## Requirements
- R1: After reset the instruction window is IMEM_BYTES long (32768 by default) and the data window is DMEM_BYTES long (16384 by default), starting at DBASE_RST.
- R2: An access whose address is below the instruction window size goes to the instruction SRAM (imem_en high).
- R3: An access that misses the instruction window and satisfies base <= address < base + data window size goes to the data SRAM (dmem_en high). The base is the data configuration word with bits [11:0] forced to zero.
- R4: Every other access goes to the external bus (ext_en high), with ext_addr equal to the request address.
- R5: A window's size in bytes is 512 shifted left by the configuration word's bits [5:1], after that shift amount is clamped to the range 3..23.
- R6: The SRAM word index is bits [n+1:2] of (address AND (min(window size, SRAM bytes) - 1)). Addresses beyond the SRAM size therefore wrap onto it.
- R7: A configuration write takes effect only when cp_crn = 9, cp_crm = 1 and cp_op1 = 0. cp_op2 = 0 selects the data window (base and size) and cp_op2 = 1 selects the instruction window (size only). Any other code leaves both windows unchanged.
- R8: req_size encodes 0 = byte, 1 = halfword, 2 or 3 = word. The byte enables are 1 << addr[1:0] for a byte, 4'b0011 or 4'b1100 (chosen by addr[1]) for a halfword, and 4'b1111 for a word. Write data is the low byte or low halfword repeated across the lanes.
- R9: A read produces rsp_valid on the following cycle. rsp_rdata carries the addressed byte or halfword of the target's little-endian word, zero-extended. Writes produce no response.
- R10: When the two windows overlap, the instruction window wins. At most one of imem_en, dmem_en and ext_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_wr | input | 1 | Configuration write strobe |
| cp_crn | input | 4 | Primary register number of the write |
| cp_crm | input | 4 | Secondary register number of the write |
| cp_op1 | input | 3 | First opcode field |
| cp_op2 | input | 3 | Second opcode field, selects the window |
| cp_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero-extended |
| imem_en | output | 1 | Instruction SRAM select |
| imem_we | output | 1 | Instruction SRAM write |
| imem_be | output | 4 | Instruction SRAM byte enables |
| imem_addr | output | IAW | Instruction SRAM word index |
| imem_wdata | output | 32 | Instruction SRAM write word |
| imem_rdata | input | 32 | Instruction SRAM read word, one cycle after select |
| dmem_en | output | 1 | Data SRAM select |
| dmem_we | output | 1 | Data SRAM write |
| dmem_be | output | 4 | Data SRAM byte enables |
| dmem_addr | output | DAW | Data SRAM word index |
| dmem_wdata | output | 32 | Data SRAM write word |
| dmem_rdata | input | 32 | Data SRAM read word, one cycle after select |
| ext_en | output | 1 | External bus select |
| ext_we | output | 1 | External bus write |
| ext_be | output | 4 | External bus byte enables |
| ext_addr | output | 32 | External bus byte address |
| ext_wdata | output | 32 | External bus write word |
| ext_rdata | input | 32 | External bus read word, one cycle after select |

## Verification
The assertions check, on every cycle, a set of per-cycle invariants:
- at most one target is selected, and every request selects one;
- the number of byte enables matches the access size;
- clamped shift amounts stay within range;
- the windows stay unchanged when no configuration write happens;
- a response follows exactly the reads.

The remaining behaviour is shown only by the bench's scenarios, which compare against an independent address model:
- exact window edges and the base masking;
- wrapping inside an oversized window;
- the clamping of extreme shift values;
- the rejection of wrong register codes;
- which lane the read data comes from.

// File: rtl/tcm_region_decoder.sv
module tcm_region_decoder #(
  parameter int          IMEM_BYTES = 32768,
  parameter int          DMEM_BYTES = 16384,
  parameter logic [31:0] DBASE_RST  = 32'h0280_0000,
  localparam int         IAW        = $clog2(IMEM_BYTES) - 2,
  localparam int         DAW        = $clog2(DMEM_BYTES) - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cp_wr,
  input  logic [3:0]     cp_crn,
  input  logic [3:0]     cp_crm,
  input  logic [2:0]     cp_op1,
  input  logic [2:0]     cp_op2,
  input  logic [31:0]    cp_wdata,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [1:0]     req_size,
  input  logic [31:0]    req_addr,
  input  logic [31:0]    req_wdata,
  output logic           rsp_valid,
  output logic [31:0]    rsp_rdata,
  output logic           imem_en,
  output logic           imem_we,
  output logic [3:0]     imem_be,
  output logic [IAW-1:0] imem_addr,
  output logic [31:0]    imem_wdata,
  input  logic [31:0]    imem_rdata,
  output logic           dmem_en,
  output logic           dmem_we,
  output logic [3:0]     dmem_be,
  output logic [DAW-1:0] dmem_addr,
  output logic [31:0]    dmem_wdata,
  input  logic [31:0]    dmem_rdata,
  output logic           ext_en,
  output logic           ext_we,
  output logic [3:0]     ext_be,
  output logic [31:0]    ext_addr,
  output logic [31:0]    ext_wdata,
  input  logic [31:0]    ext_rdata
);

  localparam logic [4:0]  I_SHIFT_RST = 5'($clog2(IMEM_BYTES) - 9);
  localparam logic [4:0]  D_SHIFT_RST = 5'($clog2(DMEM_BYTES) - 9);
  localparam logic [32:0] I_PHYS      = 33'(IMEM_BYTES);
  localparam logic [32:0] D_PHYS      = 33'(DMEM_BYTES);

  localparam logic [1:0] SEL_I = 2'd0;
  localparam logic [1:0] SEL_D = 2'd1;
  localparam logic [1:0] SEL_E = 2'd2;

  function automatic logic [4:0] clamp_shift(input logic [4:0] s);
    if (s < 5'd3)  return 5'd3;
    if (s > 5'd23) return 5'd23;
    return s;
  endfunction

  // window configuration
  logic [19:0] d_base_hi;
  logic [4:0]  d_shift, i_shift;
  logic        cfg_hit;

  assign cfg_hit = cp_wr && cp_crn == 4'd9 && cp_crm == 4'd1 && cp_op1 == 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_base_hi <= DBASE_RST[31:12];
      d_shift   <= D_SHIFT_RST;
      i_shift   <= I_SHIFT_RST;
    end else if (cfg_hit) begin
      if (cp_op2 == 3'd0) begin
        d_base_hi <= cp_wdata[31:12];
        d_shift   <= clamp_shift(cp_wdata[5:1]);
      end else if (cp_op2 == 3'd1) begin
        i_shift   <= clamp_shift(cp_wdata[5:1]);
      end
    end
  end

  // window geometry
  logic [32:0] i_size, d_size, d_lo, d_hi, addr_x, i_mask, d_mask;

  assign i_size = 33'd512 << i_shift;
  assign d_size = 33'd512 << d_shift;
  assign d_lo   = {1'b0, d_base_hi, 12'h000};
  assign d_hi   = d_lo + d_size;
  assign addr_x = {1'b0, req_addr};
  assign i_mask = ((i_size > I_PHYS) ? I_PHYS : i_size) - 33'd1;
  assign d_mask = ((d_size > D_PHYS) ? D_PHYS : d_size) - 33'd1;

  // region decode, instruction side first
  logic i_hit, d_hit;
  assign i_hit = addr_x < i_size;
  assign d_hit = !i_hit && addr_x >= d_lo && addr_x < d_hi;

  // byte lanes and write data
  logic [3:0]  lane_be;
  logic [31:0] lane_wd;

  always_comb begin
    case (req_size)
      2'd0: begin
        lane_be = 4'b0001 << req_addr[1:0];
        lane_wd = {4{req_wdata[7:0]}};
      end
      2'd1: begin
        lane_be = req_addr[1] ? 4'b1100 : 4'b0011;
        lane_wd = {2{req_wdata[15:0]}};
      end
      default: begin
        lane_be = 4'b1111;
        lane_wd = req_wdata;
      end
    endcase
  end

  assign imem_en    = req_valid && i_hit;
  assign dmem_en    = req_valid && d_hit;
  assign ext_en     = req_valid && !i_hit && !d_hit;
  assign imem_we    = imem_en && req_write;
  assign dmem_we    = dmem_en && req_write;
  assign ext_we     = ext_en && req_write;
  assign imem_be    = lane_be;
  assign dmem_be    = lane_be;
  assign ext_be     = lane_be;
  assign imem_wdata = lane_wd;
  assign dmem_wdata = lane_wd;
  assign ext_wdata  = lane_wd;
  assign imem_addr  = req_addr[IAW+1:2] & i_mask[IAW+1:2];
  assign dmem_addr  = req_addr[DAW+1:2] & d_mask[DAW+1:2];
  assign ext_addr   = req_addr;

  // read return, one cycle after the decode
  logic       rd_pend;
  logic [1:0] rd_sel, rd_off, rd_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_sel  <= SEL_E;
      rd_off  <= 2'd0;
      rd_size <= 2'd0;
    end else begin
      rd_pend <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        rd_sel  <= i_hit ? SEL_I : (d_hit ? SEL_D : SEL_E);
        rd_off  <= req_addr[1:0];
        rd_size <= req_size;
      end
    end
  end

  logic [31:0] rd_word, rd_shifted;
  assign rd_word    = (rd_sel == SEL_I) ? imem_rdata :
                      (rd_sel == SEL_D) ? dmem_rdata : ext_rdata;
  assign rd_shifted = rd_word >> {rd_off, 3'b000};

  always_comb begin
    case (rd_size)
      2'd0:    rsp_rdata = {24'h0, rd_shifted[7:0]};
      2'd1:    rsp_rdata = {16'h0, rd_shifted[15:0]};
      default: rsp_rdata = rd_word;
    endcase
  end
  assign rsp_valid = rd_pend;

  logic unused_bits;
  assign unused_bits = ^{cp_wdata[11:6], cp_wdata[0], i_mask[32:IAW+2], i_mask[1:0],
                         d_mask[32:DAW+2], d_mask[1:0], req_addr[31:IAW+2], req_addr[31:DAW+2]};

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_en, dmem_en, ext_en})); // R10
  AST_REQ_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (imem_en || dmem_en || ext_en)); // R4
  AST_LANES_MATCH_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(lane_be) == ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4)); // R8
  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    d_shift >= 5'd3 && d_shift <= 5'd23 && i_shift >= 5'd3 && i_shift <= 5'd23); // R5
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> $stable(d_base_hi) && $stable(d_shift) && $stable(i_shift)); // R7
  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R9
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R9

endmodule

// File: tb/test_tcm_region_decoder.sv
module test_tcm_region_decoder;
  localparam int          IB    = 32768;
  localparam int          DB    = 16384;
  localparam logic [31:0] DBASE = 32'h0280_0000;
  localparam int          IAW   = $clog2(IB) - 2;
  localparam int          DAW   = $clog2(DB) - 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cp_wr = 0; logic [3:0] cp_crn = 0, cp_crm = 0; logic [2:0] cp_op1 = 0, cp_op2 = 0;
  logic [31:0] cp_wdata = 0;
  logic req_valid = 0, req_write = 0; logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic rsp_valid; logic [31:0] rsp_rdata;
  logic imem_en, imem_we, dmem_en, dmem_we, ext_en, ext_we;
  logic [3:0] imem_be, dmem_be, ext_be;
  logic [IAW-1:0] imem_addr; logic [DAW-1:0] dmem_addr;
  logic [31:0] ext_addr, imem_wdata, dmem_wdata, ext_wdata;
  logic [31:0] imem_rdata = 0, dmem_rdata = 0, ext_rdata = 0;

  tcm_region_decoder #(.IMEM_BYTES(IB), .DMEM_BYTES(DB), .DBASE_RST(DBASE)) i_tcm_region_decoder (
    .clk(clk), .rst_n(rst_n), .cp_wr(cp_wr), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_op1(cp_op1),
    .cp_op2(cp_op2), .cp_wdata(cp_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .imem_en(imem_en), .imem_we(imem_we), .imem_be(imem_be),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata), .imem_rdata(imem_rdata), .dmem_en(dmem_en),
    .dmem_we(dmem_we), .dmem_be(dmem_be), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .ext_en(ext_en), .ext_we(ext_we), .ext_be(ext_be),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata));

  // memory models: one associative word store per target, key = word index
  logic [31:0] mem [3][longint];

  function automatic logic [31:0] peek(int t, longint k);
    if (mem[t].exists(k)) return mem[t][k];
    return 32'(k) * 32'h9E37_79B1 ^ 32'(t);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = wd[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (imem_en) begin
      if (imem_we) mem[0][longint'(imem_addr)] = merge(peek(0, longint'(imem_addr)), imem_wdata, imem_be);
      else imem_rdata <= peek(0, longint'(imem_addr));
    end
    if (dmem_en) begin
      if (dmem_we) mem[1][longint'(dmem_addr)] = merge(peek(1, longint'(dmem_addr)), dmem_wdata, dmem_be);
      else dmem_rdata <= peek(1, longint'(dmem_addr));
    end
    if (ext_en) begin
      if (ext_we) mem[2][longint'(ext_addr[31:2])] = merge(peek(2, longint'(ext_addr[31:2])), ext_wdata, ext_be);
      else ext_rdata <= peek(2, longint'(ext_addr[31:2]));
    end
  end

  // reference configuration
  int m_ishift, m_dshift; logic [31:0] m_dbase;
  int checks = 0, errors = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int clampv(int s);
    return s < 3 ? 3 : (s > 23 ? 23 : s);
  endfunction

  function automatic longint wsize(int s);
    return longint'(512) << s;
  endfunction

  function automatic int route(logic [31:0] a);
    longint la = longint'(a);
    if (la < wsize(m_ishift)) return 0;
    if (la >= longint'(m_dbase) && la < longint'(m_dbase) + wsize(m_dshift)) return 1;
    return 2;
  endfunction

  function automatic longint index_of(int t, logic [31:0] a);
    longint sz = wsize(t == 0 ? m_ishift : m_dshift);
    longint ph = (t == 0) ? IB : DB;
    longint mk = (sz < ph ? sz : ph) - 1;
    if (t == 2) return longint'(a[31:2]);
    return (longint'(a) & mk) >> 2;
  endfunction

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] o);
    if (sz == 0) return 4'b0001 << o;
    if (sz == 1) return o[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(logic [1:0] sz, logic [31:0] w);
    if (sz == 0) return {4{w[7:0]}};
    if (sz == 1) return {2{w[15:0]}};
    return w;
  endfunction

  task automatic cfg_write(logic [3:0] crn, logic [3:0] crm, logic [2:0] op1, logic [2:0] op2, logic [31:0] v);
    @(negedge clk);
    cp_wr = 1; cp_crn = crn; cp_crm = crm; cp_op1 = op1; cp_op2 = op2; cp_wdata = v;
    @(negedge clk);
    cp_wr = 0;
    if (crn == 9 && crm == 1 && op1 == 0) begin
      if (op2 == 0) begin m_dbase = {v[31:12], 12'h000}; m_dshift = clampv(int'(v[5:1])); end
      else if (op2 == 1) m_ishift = clampv(int'(v[5:1]));
    end
  endtask

  task automatic access(string rtag, logic wr, logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
    int t; longint k; logic [31:0] word, sh, expr;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    #1;
    t = route(a); k = index_of(t, a);
    check(rtag, {29'b0, imem_en, dmem_en, ext_en}, (t == 0) ? 32'd4 : (t == 1) ? 32'd2 : 32'd1);
    if (t == 0) check("R6", 32'(imem_addr), 32'(k));
    else if (t == 1) check("R6", 32'(dmem_addr), 32'(k));
    else check("R4", ext_addr, a);
    check("R8", {28'b0, (t == 0) ? imem_be : (t == 1) ? dmem_be : ext_be}, {28'b0, exp_be(sz, a[1:0])});
    if (wr) check("R8", (t == 0) ? imem_wdata : (t == 1) ? dmem_wdata : ext_wdata, exp_wd(sz, wd));
    word = peek(t, k);
    sh = word >> {a[1:0], 3'b000};
    expr = (sz == 0) ? {24'h0, sh[7:0]} : (sz == 1) ? {16'h0, sh[15:0]} : word;
    @(negedge clk);
    req_valid = 0;
    check("R9", {31'b0, rsp_valid}, {31'b0, !wr});
    if (!wr) check("R9", rsp_rdata, expr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ishift = 6; m_dshift = 5; m_dbase = DBASE;
    repeat (3) @(negedge clk);
    check("R1", {29'b0, imem_en, dmem_en, ext_en}, 32'd0);
    check("R9", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;

    // reset windows and edges
    access("R1", 0, 2'd2, 32'h0000_7FFC, 0);
    access("R1", 0, 2'd2, 32'h0000_8000, 0);
    access("R1", 0, 2'd2, DBASE, 0);
    access("R1", 0, 2'd2, DBASE + 32'h3FFC, 0);
    access("R4", 0, 2'd2, DBASE + 32'h4000, 0);
    access("R4", 0, 2'd2, DBASE - 4, 0);
    // lanes and read-back
    access("R2", 1, 2'd0, 32'h0000_0103, 32'h0000_00A5);
    access("R2", 0, 2'd0, 32'h0000_0103, 0);
    access("R3", 1, 2'd1, DBASE + 32'h12, 32'h0000_BEEF);
    access("R3", 0, 2'd1, DBASE + 32'h12, 0);
    access("R4", 1, 2'd2, 32'hF000_0040, 32'h1234_5678);
    access("R4", 0, 2'd0, 32'hF000_0041, 0);
    // base masking and mirroring: 512 KiB data window over 16 KiB
    cfg_write(4'd9, 4'd1, 3'd0, 3'd0, 32'h0100_0ABC | (32'd10 << 1));
    access("R3", 0, 2'd2, 32'h0100_0000, 0);
    access("R6", 1, 2'd2, 32'h0100_4008, 32'hCAFE_F00D);
    access("R6", 0, 2'd2, 32'h0100_0008, 0);
    access("R5", 0, 2'd2, 32'h0107_FFFC, 0);
    access("R5", 0, 2'd2, 32'h0108_0000, 0);
    // clamp low: shift field 0 gives 4 KiB
    cfg_write(4'd9, 4'd1, 3'd0, 3'd1, 32'h0000_0000);
    access("R5", 0, 2'd2, 32'h0000_0FFC, 0);
    access("R5", 0, 2'd2, 32'h0000_1000, 0);
    // ignored codes
    cfg_write(4'd9, 4'd1, 3'd0, 3'd2, 32'h0000_003E);
    cfg_write(4'd9, 4'd2, 3'd0, 3'd1, 32'h0000_003E);
    cfg_write(4'd8, 4'd1, 3'd0, 3'd0, 32'h0000_003E);
    cfg_write(4'd9, 4'd1, 3'd1, 3'd1, 32'h0000_003E);
    access("R7", 0, 2'd2, 32'h0000_1000, 0);
    access("R7", 0, 2'd2, 32'h0100_0000, 0);
    // overlap: data window at 0, instruction wins
    cfg_write(4'd9, 4'd1, 3'd0, 3'd0, 32'h0000_0000 | (32'd5 << 1));
    access("R10", 0, 2'd2, 32'h0000_0100, 0);
    access("R10", 0, 2'd2, 32'h0000_1100, 0);
    // clamp high: everything falls in the instruction window
    cfg_write(4'd9, 4'd1, 3'd0, 3'd1, 32'h0000_003E);
    access("R5", 0, 2'd2, 32'hFFFF_FFFC, 0);
    access("R6", 0, 2'd2, 32'h8000_8004, 0);
    cfg_write(4'd9, 4'd1, 3'd0, 3'd1, 32'd6 << 1);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int pick = int'($urandom % 10);
      logic [31:0] a; longint la;
      if (pick == 0) begin
        logic [31:0] v = ($urandom & 32'h0FFF_FFC0) | (32'($urandom % 16) << 1);
        cfg_write(4'd9, ($urandom % 4 == 0) ? 4'd2 : 4'd1, 3'd0, 3'($urandom % 3), v);
      end else begin
        if (pick < 4) la = longint'($urandom) % wsize(m_ishift);
        else if (pick < 8) la = longint'(m_dbase) + longint'($urandom) % wsize(m_dshift);
        else la = longint'($urandom);
        a = 32'(la);
        access("R3", 1'($urandom), 2'($urandom), a, $urandom);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule